// File: doc/BRIEF.md
# Multi-Lane Framing Token Detector

This block watches the descrambled receive symbols of a multi-lane 8 GT/s link and finds the framing tokens that begin link-layer and transaction-layer packets. Each cycle it takes one byte from every lane. It reads them in increasing lane order, so the packet bytes form one continuous symbol stream across lanes and across cycles. It opens the stream when a start-of-data-stream ordered set arrives. From then on it searches only inside data blocks.

When it finds a data-link packet token, it collects the six packet bytes, which may span two cycles. It then raises a one-cycle strobe carrying the bytes, a decoded flow-control kind, and the header and data credit counts as binary numbers. When it finds a transaction packet token, it raises a one-cycle strobe with the lane that held the token. It reads the length field of that token and steps over the packet body, so payload bytes are never taken for tokens. If several packets start in one cycle, the lowest lane is reported.

The input has a valid qualifier and no ready: the receive path cannot be stalled, so the block accepts every valid cycle. A cycle with the qualifier low is a hole in the stream. The outputs are strobes with no back-pressure: each is high for exactly one cycle and must be consumed in that cycle.

Top module: `ftd_top`

## Requirements
- R1: After reset, `dllp_valid` and `tlp_start` are low. Until a start-of-data-stream block has been seen, no token is detected, even inside data blocks.
- R2: A block start (`rx_start_block`=1) whose sync header is not 2'b10 ends the stream and drops any packet in progress. The exception is an ordered-set block (2'b01) whose lane-0 byte is E1: it opens the stream.
- R3: Only cycles of data blocks (block opened with sync header 2'b10) are searched. The remaining cycles of the start-of-data-stream block are not searched.
- R4: Lane i is `rx_data[8*i+7:8*i]`. Symbols are consumed in increasing lane order, and lane LANES-1 of one valid cycle is followed by lane 0 of the next valid cycle.
- R5: A data-link token is F0 followed by AC. F0 is recognised only when it lies in a lane whose index is a multiple of 4 (0, 4, 8). Elsewhere it is ignored. F0 not followed by AC is dropped.
- R6: The six symbols after AC form the packet, with byte k at `dllp_bytes[8*k+7:8*k]`. `dllp_valid` pulses in the cycle after the input cycle that carried the sixth byte, including when the packet spans two cycles.
- R7: `dllp_kind` is decoded from byte 0 when bit 3 of byte 0 is 0. Upper nibble 4 gives 1 (initial posted credit), 5 gives 2 (initial non-posted), 6 gives 3 (initial completion) and 8 gives 4 (posted update). Every other byte 0 gives 0.
- R8: `fc_hdr` = {byte1[5:0], byte2[7:6]} and `fc_data` = {byte2[3:0], byte3}, both as plain binary.
- R9: Outside any packet, a symbol with low nibble F in any lane is a transaction token. `tlp_start` pulses in the next cycle, with `tlp_lane` set to that lane.
- R10: The token length L is {byte1[6:0], byte0[7:4]} in doublewords. The block steps over 4*L symbols counted from byte 0, or over 4 symbols if L < 2, before it searches again.
- R11: A cycle with `rx_valid` low carries no symbols and advances no state. The next cycle shows no strobe that it could have caused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Symbols on `rx_data` are valid this cycle |
| rx_start_block | input | 1 | This cycle begins a new block |
| rx_sync_hdr | input | 2 | Block type at a block start: 2'b01 ordered set, 2'b10 data |
| rx_data | input | 8*LANES | One descrambled byte per lane |
| dllp_valid | output | 1 | One-cycle strobe: data-link packet captured |
| dllp_bytes | output | 48 | The six packet bytes, byte 0 lowest |
| dllp_kind | output | 3 | Flow-control kind code |
| fc_hdr | output | 8 | Header credit count |
| fc_data | output | 12 | Data credit count |
| tlp_start | output | 1 | One-cycle strobe: transaction packet token found |
| tlp_lane | output | LW | Lane of that token |

## Verification
Every result is due exactly one clock after the input cycle that completes it. For a data-link packet, that input cycle carries the sixth byte. For a transaction start, it carries the token's first symbol. Inputs change on the falling edge. At each following falling edge, the bench compares both strobes and all their fields against values it computed from the symbol offset, so any early, late or extra strobe fails. Stall cycles are counted in that timing, and they carry false token bytes that must leave no trace.

// File: rtl/ftd_pkg.sv
package ftd_pkg;
  localparam logic [7:0] SYM_SDP_A = 8'hF0;
  localparam logic [7:0] SYM_SDP_B = 8'hAC;
  localparam logic [7:0] SYM_SDS   = 8'hE1;
  localparam logic [1:0] SYNC_OS   = 2'b01;
  localparam logic [1:0] SYNC_DATA = 2'b10;
  localparam int DLLP_SYMS = 6;
  localparam int SKIP_W    = 13;

  typedef enum logic [2:0] {
    WK_IDLE, WK_SDP_B, WK_DLLP, WK_STP_B, WK_SKIP
  } walk_e;

  typedef enum logic [2:0] {
    FC_NONE = 3'd0, FC_INIT_P = 3'd1, FC_INIT_NP = 3'd2,
    FC_INIT_CPL = 3'd3, FC_UPD_P = 3'd4
  } dllp_kind_e;
endpackage

// File: rtl/ftd_block_track.sv
module ftd_block_track
  import ftd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       valid,
  input  logic       start,
  input  logic [1:0] sync,
  input  logic [7:0] lane0,
  output logic       search,
  output logic       clr
);
  logic stream_q, data_q;
  logic is_start, data_start;

  always_comb begin
    is_start   = valid && start;
    data_start = is_start && (sync == SYNC_DATA);
    clr        = is_start && (sync != SYNC_DATA);
    search     = valid && stream_q && (is_start ? data_start : data_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stream_q <= 1'b0;
      data_q   <= 1'b0;
    end else if (is_start) begin
      data_q <= (sync == SYNC_DATA);
      if (sync != SYNC_DATA)
        stream_q <= (sync == SYNC_OS) && (lane0 == SYM_SDS);
    end
  end
endmodule

// File: rtl/ftd_lane_walk.sv
module ftd_lane_walk
  import ftd_pkg::*;
#(
  parameter int LANES = 4,
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               search,
  input  logic               clr,
  input  logic [8*LANES-1:0] data,
  output logic               hit_dllp,
  output logic [47:0]        hit_bytes,
  output logic               hit_tlp,
  output logic [LW-1:0]      hit_lane
);
  walk_e             mode_q, m;
  logic [SKIP_W-1:0] cnt_q, c, rem;
  logic [3:0]        hi_q, hi;
  logic [47:0]       buf_q, bf;
  logic [10:0]       len;
  logic [7:0]        b;
  logic              done, tfound;
  logic [LW-1:0]     tlane;

  always_comb begin
    m = mode_q; c = cnt_q; hi = hi_q; bf = buf_q;
    done = 1'b0; tfound = 1'b0; tlane = '0;
    len = '0; rem = '0; b = '0;
    for (int i = 0; i < LANES; i++) begin
      b = data[8*i +: 8];
      unique case (m)
        WK_IDLE: begin
          if (b == SYM_SDP_A && (i % 4) == 0) begin
            m = WK_SDP_B;
          end else if (b[3:0] == 4'hF) begin
            m  = WK_STP_B;
            hi = b[7:4];
            if (!tfound) begin
              tfound = 1'b1;
              tlane  = LW'(i);
            end
          end
        end
        WK_SDP_B: begin
          if (b == SYM_SDP_B) begin
            m = WK_DLLP;
            c = '0;
          end else begin
            m = WK_IDLE;
          end
        end
        WK_DLLP: begin
          bf[{c[2:0], 3'b000} +: 8] = b;
          if (c == SKIP_W'(DLLP_SYMS - 1)) begin
            m    = WK_IDLE;
            done = 1'b1;
          end else begin
            c = c + 1'b1;
          end
        end
        WK_STP_B: begin
          len = {b[6:0], hi};
          rem = (len < 11'd2) ? SKIP_W'(2) : ({len, 2'b00} - SKIP_W'(2));
          m   = WK_SKIP;
          c   = rem;
        end
        WK_SKIP: begin
          if (c == SKIP_W'(1)) m = WK_IDLE;
          c = c - 1'b1;
        end
        default: m = WK_IDLE;
      endcase
    end
    hit_dllp  = search && done;
    hit_tlp   = search && tfound;
    hit_lane  = tlane;
    hit_bytes = bf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= WK_IDLE;
      cnt_q  <= '0;
      hi_q   <= '0;
      buf_q  <= '0;
    end else if (clr) begin
      mode_q <= WK_IDLE;
      cnt_q  <= '0;
    end else if (search) begin
      mode_q <= m;
      cnt_q  <= c;
      hi_q   <= hi;
      buf_q  <= bf;
    end
  end
endmodule

// File: rtl/ftd_dllp_decode.sv
module ftd_dllp_decode
  import ftd_pkg::*;
(
  input  logic [47:0] bytes,
  output logic [2:0]  kind,
  output logic [7:0]  hdr,
  output logic [11:0] dat
);
  logic [7:0] b0, b1, b2, b3;
  dllp_kind_e k;

  always_comb begin
    b0 = bytes[7:0];
    b1 = bytes[15:8];
    b2 = bytes[23:16];
    b3 = bytes[31:24];
    k  = FC_NONE;
    if (!b0[3]) begin
      unique case (b0[7:4])
        4'h4:    k = FC_INIT_P;
        4'h5:    k = FC_INIT_NP;
        4'h6:    k = FC_INIT_CPL;
        4'h8:    k = FC_UPD_P;
        default: k = FC_NONE;
      endcase
    end
    kind = k;
    hdr  = {b1[5:0], b2[7:6]};
    dat  = {b2[3:0], b3};
  end
endmodule

// File: rtl/ftd_top.sv
module ftd_top
  import ftd_pkg::*;
#(
  parameter int LANES = 4,
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_valid,
  input  logic               rx_start_block,
  input  logic [1:0]         rx_sync_hdr,
  input  logic [8*LANES-1:0] rx_data,
  output logic               dllp_valid,
  output logic [47:0]        dllp_bytes,
  output logic [2:0]         dllp_kind,
  output logic [7:0]         fc_hdr,
  output logic [11:0]        fc_data,
  output logic               tlp_start,
  output logic [LW-1:0]      tlp_lane
);
  logic          search, clr;
  logic          hit_dllp, hit_tlp;
  logic [47:0]   hit_bytes;
  logic [LW-1:0] hit_lane;
  logic [2:0]    kind_d;
  logic [7:0]    hdr_d;
  logic [11:0]   dat_d;

  ftd_block_track u_track (
    .clk(clk), .rst_n(rst_n), .valid(rx_valid), .start(rx_start_block),
    .sync(rx_sync_hdr), .lane0(rx_data[7:0]), .search(search), .clr(clr)
  );

  ftd_lane_walk #(.LANES(LANES)) u_walk (
    .clk(clk), .rst_n(rst_n), .search(search), .clr(clr), .data(rx_data),
    .hit_dllp(hit_dllp), .hit_bytes(hit_bytes),
    .hit_tlp(hit_tlp), .hit_lane(hit_lane)
  );

  ftd_dllp_decode u_dec (
    .bytes(hit_bytes), .kind(kind_d), .hdr(hdr_d), .dat(dat_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dllp_valid <= 1'b0;
      dllp_bytes <= '0;
      dllp_kind  <= '0;
      fc_hdr     <= '0;
      fc_data    <= '0;
      tlp_start  <= 1'b0;
      tlp_lane   <= '0;
    end else begin
      dllp_valid <= hit_dllp;
      tlp_start  <= hit_tlp;
      if (hit_dllp) begin
        dllp_bytes <= hit_bytes;
        dllp_kind  <= kind_d;
        fc_hdr     <= hdr_d;
        fc_data    <= dat_d;
      end
      if (hit_tlp) tlp_lane <= hit_lane;
    end
  end
endmodule

// File: rtl/ftd_checker.sv
module ftd_checker #(
  parameter int LANES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rx_valid,
  input logic               rx_start_block,
  input logic [1:0]         rx_sync_hdr,
  input logic               dllp_valid,
  input logic [47:0]        dllp_bytes,
  input logic [2:0]         dllp_kind,
  input logic               tlp_start
);
  p_stall_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (dllp_valid || tlp_start) |-> $past(rx_valid));

  p_nondata_start_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_start_block && rx_sync_hdr != 2'b10) |=> (!dllp_valid && !tlp_start));

  p_initp_kind_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dllp_valid && dllp_bytes[7:0] == 8'h40) |-> (dllp_kind == 3'd1));

  p_update_kind_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dllp_valid && dllp_bytes[7:0] == 8'h80) |-> (dllp_kind == 3'd4));

  p_kind_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dllp_valid |-> (dllp_kind <= 3'd4));
endmodule

bind ftd_top ftd_checker #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_start_block(rx_start_block),
  .rx_sync_hdr(rx_sync_hdr), .dllp_valid(dllp_valid), .dllp_bytes(dllp_bytes),
  .dllp_kind(dllp_kind), .tlp_start(tlp_start)
);

// File: tb/sim_ftd_top.sv
`timescale 1ns/1ps
module sim_ftd_top;
  localparam int LANES = 4;
  localparam int LW = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic               rst_n = 1'b0;
  logic               rx_valid = 1'b0, rx_start_block = 1'b0;
  logic [1:0]         rx_sync_hdr = 2'b00;
  logic [8*LANES-1:0] rx_data = '0;
  logic               dllp_valid, tlp_start;
  logic [47:0]        dllp_bytes;
  logic [2:0]         dllp_kind;
  logic [7:0]         fc_hdr;
  logic [11:0]        fc_data;
  logic [LW-1:0]      tlp_lane;

  ftd_top #(.LANES(LANES)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_start_block(rx_start_block),
    .rx_sync_hdr(rx_sync_hdr), .rx_data(rx_data), .dllp_valid(dllp_valid),
    .dllp_bytes(dllp_bytes), .dllp_kind(dllp_kind), .fc_hdr(fc_hdr), .fc_data(fc_data),
    .tlp_start(tlp_start), .tlp_lane(tlp_lane)
  );

  int nchk = 0, nerr = 0;
  logic [7:0] st [0:127];

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic int ekind(input logic [7:0] b);
    if (b[3]) return 0;
    case (b[7:4])
      4'h4: return 1;
      4'h5: return 2;
      4'h6: return 3;
      4'h8: return 4;
      default: return 0;
    endcase
  endfunction

  task automatic idle();
    rx_valid = 1'b0; rx_start_block = 1'b0; rx_sync_hdr = 2'b00; rx_data = '0;
  endtask

  task automatic do_reset();
    idle();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic clear_st();
    for (int i = 0; i < 128; i++) st[i] = 8'h00;
  endtask

  task automatic send_sds();
    rx_valid = 1'b1; rx_start_block = 1'b1; rx_sync_hdr = 2'b01;
    rx_data = {8'h55, 8'h55, 8'h55, 8'hE1};
    @(negedge clk);
  endtask

  task automatic expect_quiet(input string rq);
    chk(dllp_valid == 1'b0, rq, "dllp_valid", 64'(dllp_valid), 64'd0);
    chk(tlp_start == 1'b0, rq, "tlp_start", 64'(tlp_start), 64'd0);
  endtask

  // Feed st[0..nsym-1] as one data block; dc/t1/t2 are data-cycle indices of expected strobes.
  task automatic run(input int nsym, input int dc, input logic [47:0] eb,
                     input int t1, input int l1, input int t2, input int l2,
                     input int gap, input string rq);
    int nc, total;
    nc = (nsym + LANES - 1) / LANES;
    total = nc + ((gap >= 0) ? 1 : 0);
    for (int t = 0; t <= total; t++) begin
      int j;
      bit stall, et;
      stall = (gap >= 0 && t == gap);
      j = (t >= total) ? -2 : (stall ? -1 : ((gap >= 0 && t > gap) ? t - 1 : t));
      if (t < total) begin
        rx_valid = !stall;
        rx_start_block = (j == 0);
        rx_sync_hdr = 2'b10;
        for (int l = 0; l < LANES; l++)
          rx_data[8*l +: 8] = stall ? 8'hF0 : ((j*LANES + l < nsym) ? st[j*LANES + l] : 8'h00);
      end else begin
        idle();
      end
      @(negedge clk);
      chk(dllp_valid == (j >= 0 && j == dc), rq, "dllp_valid timing",
          64'(dllp_valid), 64'(j >= 0 && j == dc));
      et = (j >= 0) && (j == t1 || j == t2);
      chk(tlp_start == et, "R9", "tlp_start timing", 64'(tlp_start), 64'(et));
      if (j >= 0 && j == dc) begin
        chk(dllp_bytes == eb, "R6", "dllp_bytes", 64'(dllp_bytes), 64'(eb));
        chk(int'(dllp_kind) == ekind(eb[7:0]), "R7", "dllp_kind", 64'(dllp_kind), 64'(ekind(eb[7:0])));
        chk(fc_hdr == {eb[13:8], eb[23:22]}, "R8", "fc_hdr", 64'(fc_hdr), 64'({eb[13:8], eb[23:22]}));
        chk(fc_data == {eb[19:16], eb[31:24]}, "R8", "fc_data", 64'(fc_data), 64'({eb[19:16], eb[31:24]}));
      end
      if (tlp_start && j >= 0 && j == t1)
        chk(int'(tlp_lane) == l1, "R9", "tlp_lane", 64'(tlp_lane), 64'(l1));
      if (tlp_start && j >= 0 && j == t2 && j != t1)
        chk(int'(tlp_lane) == l2, "R10", "tlp_lane second", 64'(tlp_lane), 64'(l2));
    end
  endtask

  initial begin
    #1000000;
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic [7:0] types [6];
    int lens [4];
    logic [47:0] eb;
    types = '{8'h40, 8'h50, 8'h60, 8'h80, 8'h47, 8'h30};
    lens  = '{1, 2, 3, 6};

    repeat (3) @(negedge clk);
    expect_quiet("R1");           // reset state
    rst_n = 1'b1;

    // R1: data block without preceding SDS yields nothing
    clear_st();
    st[0] = 8'hF0; st[1] = 8'hAC; st[2] = 8'h40; st[4] = 8'h2F;
    run(8, -1, '0, -1, 0, -1, 0, -1, "R1");

    // R5 R6 R7 R8 R4: DLLP sweep over symbol offset and type byte
    for (int off = 0; off < 8; off++) begin
      for (int k = 0; k < 6; k++) begin
        do_reset();
        send_sds();
        clear_st();
        eb = {8'h34, 8'h12, 8'h5C ^ 8'(k*16), 8'hC3, 8'(8'h1A + off*8), types[k]};
        st[off] = 8'hF0; st[off+1] = 8'hAC;
        for (int q = 0; q < 6; q++) st[off+2+q] = eb[8*q +: 8];
        run(off + 8, ((off % 4) == 0) ? (off + 7) / 4 : -1, eb, -1, 0, -1, 0, -1,
            ((off % 4) == 0) ? "R6" : "R5");
      end
    end

    // R9 R10: STP sweep over offset and length, body full of false tokens, then a second STP
    for (int off = 0; off < 8; off++) begin
      for (int k = 0; k < 4; k++) begin
        int span, p2;
        span = (lens[k] < 2) ? 4 : 4 * lens[k];
        p2 = off + span;
        do_reset();
        send_sds();
        clear_st();
        st[off] = {4'(lens[k]), 4'hF};
        st[off+1] = 8'h00;
        for (int q = 2; q < span; q++) st[off+q] = 8'hAF;
        st[p2] = 8'h1F; st[p2+1] = 8'h00; st[p2+2] = 8'hAF; st[p2+3] = 8'hAF;
        run(p2 + 4, -1, '0, off / 4, off % 4, p2 / 4, p2 % 4, -1, "R10");
      end
    end

    // R11: stall cycle in the middle of a spanning DLLP carries false F0s
    do_reset();
    send_sds();
    clear_st();
    eb = {8'h66, 8'h77, 8'h01, 8'hFE, 8'h3F, 8'h80};
    st[0] = 8'hF0; st[1] = 8'hAC;
    for (int q = 0; q < 6; q++) st[2+q] = eb[8*q +: 8];
    run(8, 1, eb, -1, 0, -1, 0, 1, "R11");

    // R3: symbols in the SDS block's later cycles are not searched
    do_reset();
    send_sds();
    rx_valid = 1'b1; rx_start_block = 1'b0; rx_sync_hdr = 2'b10;
    rx_data = {8'h11, 8'h40, 8'hAC, 8'hF0};
    @(negedge clk);
    expect_quiet("R3");
    rx_data = {8'h55, 8'h44, 8'h3F, 8'h22};
    @(negedge clk);
    expect_quiet("R3");
    idle();
    @(negedge clk);
    expect_quiet("R3");

    // R2: ordered-set block start drops a DLLP in progress and closes the stream
    do_reset();
    send_sds();
    rx_valid = 1'b1; rx_start_block = 1'b1; rx_sync_hdr = 2'b10;
    rx_data = {8'h11, 8'h40, 8'hAC, 8'hF0};
    @(negedge clk);
    expect_quiet("R2");
    rx_sync_hdr = 2'b01;
    rx_data = {8'h00, 8'h00, 8'h00, 8'h1E};
    @(negedge clk);
    expect_quiet("R2");
    clear_st();
    st[0] = 8'hF0; st[1] = 8'hAC; st[2] = 8'h60; st[5] = 8'h4F;
    run(8, -1, '0, -1, 0, -1, 0, -1, "R2");

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule